// File: doc/BRIEF.md
# RTU Frame Gap Delimiter

This block sits behind a UART byte receiver on a binary serial field bus in which frames carry no delimiter characters. It times the silence between byte strobes in system clock cycles and finds frame edges from that silence alone. Two thresholds are used: an inter-character limit of 1.5 character times and a frame-separating gap of 3.5 character times, where one character time is 11 bit periods at the configured baud rate.

A byte that follows a long enough silence opens a frame and raises a start pulse. Later bytes are forwarded with a one-byte delay, so that the final byte can be tagged as last when the closing silence is detected, and downstream logic can find the two trailing check bytes. A byte that arrives after too long a pause inside a frame marks the frame as corrupt. The rest of that frame is then dropped, and only its closing pulse is reported, with the error flag raised.

Top module: `rtu_gap_framer`

## Requirements
- R1: The thresholds are T15 = (CLK_HZ/BAUD)*33/2 and T35 = (CLK_HZ/BAUD)*77/2 clock cycles, using integer division; "idle run" means the number of consecutive cycles with `rx_valid` low.
- R2: After reset all outputs are low, and strobes are ignored until an idle run of T35 cycles has been seen.
- R3: A strobe that follows an idle run of at least T35 cycles (after the first such run) opens a frame: `sof` is high for exactly the one cycle after that strobe.
- R4: A strobe inside an open frame that follows an idle run longer than T15 cycles raises `frame_err` in the next cycle. The byte held at that point and every later byte of the frame are not forwarded.
- R5: `eof` pulses for one cycle, in the cycle after the T35-th consecutive idle cycle of an open frame, whether that frame is good or errored. It pulses only once per frame.
- R6: Bytes of a good frame appear on `out_data` in arrival order. Each byte is emitted in the cycle after the next strobe, and the final byte is emitted with `out_last` high in the same cycle as `eof`.
- R7: A strobe after an idle run of exactly T15 cycles is accepted. A strobe after an idle run between T15+1 and T35-1 cycles errors the frame and does not open a new one.
- R8: `frame_err` stays high after its frame ends and is cleared by the `sof` of the next frame.
- R9: A strobe during the post-reset wait, or inside an errored frame, restarts the idle run, so the T35 wait starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe per received byte |
| rx_data | input | 8 | Received byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the final byte of the frame |
| sof | output | 1 | Frame opened |
| eof | output | 1 | Frame closed by silence |
| frame_err | output | 1 | Current or last frame had an over-long inner gap |

## Verification
The bench targets idle runs of exactly T15, T15+1 and T35-1 cycles. A design that is off by one in its comparison would accept or reject a byte one cycle early or late at these points. A one-byte frame and a stray strobe during the post-reset wait are also driven. A design that mistimed the first of these would lose the only byte or fail to tag it last. A design that mishandled the second would open a frame too early. Errored frames are followed directly by good ones, which exposes an error flag that does not clear or bytes that leak from a discarded frame.

// File: rtl/rtu_gap_pkg.sv
package rtu_gap_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_IDLE = 2'd1,
      ST_OPEN = 2'd2,
      ST_BAD  = 2'd3
   } gap_state_e;

   function automatic int unsigned gap_cycles(input int unsigned clk_hz,
                                              input int unsigned baud,
                                              input int unsigned half_chars);
      return ((clk_hz / baud) * 11 * half_chars) / 2;
   endfunction
endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
   parameter int unsigned T15_CYC = 33,
   parameter int unsigned T35_CYC = 77,
   parameter int unsigned CNT_W   = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic gap_long,
   output logic silence_hit
);
   logic [CNT_W-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_cnt <= '0;
      else if (strobe)
         idle_cnt <= '0;
      else if (idle_cnt < CNT_W'(T35_CYC))
         idle_cnt <= idle_cnt + 1'b1;
   end

   assign gap_long    = idle_cnt > CNT_W'(T15_CYC);
   assign silence_hit = !strobe && (idle_cnt == CNT_W'(T35_CYC - 1));

   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt <= CNT_W'(T35_CYC));
   p_strobe_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !silence_hit);
endmodule

// File: rtl/rtu_gap_fsm.sv
module rtu_gap_fsm
   import rtu_gap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic gap_long,
   input  logic silence_hit,
   output logic load_first,
   output logic push,
   output logic close,
   output logic sof,
   output logic eof,
   output logic frame_err
);
   gap_state_e state, state_nx;
   logic       err_nx;

   always_comb begin
      state_nx   = state;
      err_nx     = frame_err;
      load_first = 1'b0;
      push       = 1'b0;
      close      = 1'b0;
      if (strobe) begin
         unique case (state)
            ST_IDLE: begin
               load_first = 1'b1;
               err_nx     = 1'b0;
               state_nx   = ST_OPEN;
            end
            ST_OPEN: begin
               if (gap_long) begin
                  err_nx   = 1'b1;
                  state_nx = ST_BAD;
               end else begin
                  push = 1'b1;
               end
            end
            default: state_nx = state;
         endcase
      end else if (silence_hit) begin
         close    = (state == ST_OPEN);
         state_nx = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         sof       <= 1'b0;
         eof       <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         state     <= state_nx;
         sof       <= load_first;
         eof       <= silence_hit && (state == ST_OPEN || state == ST_BAD);
         frame_err <= err_nx;
      end
   end

   p_eof_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eof |=> !eof);
   p_sof_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> $past(strobe));
   p_sof_clears_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> !frame_err);
   p_controls_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_first, push, close}));
endmodule

// File: rtl/rtu_gap_hold.sv
module rtu_gap_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              load_first,
   input  logic              push,
   input  logic              close,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   logic [DATA_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= push || close;
         out_last  <= close;
         if (push || close)
            out_data <= held;
         if (load_first || push)
            held <= in_data;
      end
   end

   p_last_is_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

// File: rtl/rtu_gap_framer.sv
module rtu_gap_framer
   import rtu_gap_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLK_HZ  = 50_000_000,
   parameter int unsigned BAUD    = 9600,
   parameter int unsigned T15_CYC = gap_cycles(CLK_HZ, BAUD, 3),
   parameter int unsigned T35_CYC = gap_cycles(CLK_HZ, BAUD, 7)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              sof,
   output logic              eof,
   output logic              frame_err
);
   localparam int unsigned CNT_W = $clog2(T35_CYC + 1);

   if (T35_CYC <= T15_CYC + 1) begin : g_bad_thresholds
      $error("rtu_gap_framer: T35_CYC must exceed T15_CYC + 1");
   end
   if (T15_CYC == 0) begin : g_bad_t15
      $error("rtu_gap_framer: T15_CYC must be nonzero");
   end

   logic gap_long, silence_hit;
   logic load_first, push, close;

   rtu_gap_timer #(
      .T15_CYC(T15_CYC),
      .T35_CYC(T35_CYC),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (rx_valid),
      .gap_long   (gap_long),
      .silence_hit(silence_hit)
   );

   rtu_gap_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (rx_valid),
      .gap_long   (gap_long),
      .silence_hit(silence_hit),
      .load_first (load_first),
      .push       (push),
      .close      (close),
      .sof        (sof),
      .eof        (eof),
      .frame_err  (frame_err)
   );

   rtu_gap_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (rx_data),
      .load_first(load_first),
      .push      (push),
      .close     (close),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   p_no_fwd_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !frame_err);
   p_last_with_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> eof);
   p_sof_eof_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sof && eof));
endmodule

// File: tb/rtu_gap_framer_tb.sv
module rtu_gap_framer_tb;
   localparam int CHAR_RATIO = 200 / 100;
   localparam int B_T15 = CHAR_RATIO * 11 * 3 / 2;
   localparam int B_T35 = CHAR_RATIO * 11 * 7 / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       out_valid, out_last, sof, eof, frame_err;
   logic [7:0] out_data;

   int checks = 0;
   int failures = 0;

   // reference state: 0 wait-after-reset, 1 idle, 2 open, 3 errored
   int         m_st = 0;
   int         m_run = 0;
   logic [7:0] m_held = 8'h00;
   logic e_sof = 0, e_eof = 0, e_ov = 0, e_ol = 0, e_err = 0;
   logic [7:0] e_od = 8'h00;

   always #2.5 clk = ~clk;

   rtu_gap_framer #(.DATA_W(8), .CLK_HZ(200), .BAUD(100)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .sof(sof), .eof(eof), .frame_err(frame_err)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R3", "sof", {7'd0, sof}, {7'd0, e_sof});
      check("R5", "eof", {7'd0, eof}, {7'd0, e_eof});
      check("R4", "frame_err", {7'd0, frame_err}, {7'd0, e_err});
      check("R6", "out_valid", {7'd0, out_valid}, {7'd0, e_ov});
      if (e_ov) begin
         check("R6", "out_data", out_data, e_od);
         check("R6", "out_last", {7'd0, out_last}, {7'd0, e_ol});
      end
   endtask

   // one clock: compare at negedge, drive, advance the reference
   task automatic step(input logic v, input logic [7:0] d);
      @(negedge clk);
      compare_all();
      rx_valid = v;
      rx_data  = d;
      e_sof = 0; e_eof = 0; e_ov = 0; e_ol = 0;
      if (v) begin
         if (m_st == 1) begin
            e_sof = 1; e_err = 0; m_held = d; m_st = 2;
         end else if (m_st == 2) begin
            if (m_run > B_T15) begin
               e_err = 1; m_st = 3;
            end else begin
               e_ov = 1; e_od = m_held; m_held = d;
            end
         end
         m_run = 0;
      end else begin
         if (m_run == B_T35 - 1) begin
            if (m_st == 2) begin
               e_ov = 1; e_od = m_held; e_ol = 1; e_eof = 1;
            end else if (m_st == 3) begin
               e_eof = 1;
            end
            m_st = 1;
         end
         if (m_run < B_T35) m_run++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00);
   endtask

   task automatic byte_after(input int gap, input logic [7:0] d);
      idle(gap);
      step(1'b1, d);
   endtask

   initial begin
      #(5 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      // R2: reset state
      check("R2", "sof after reset", {7'd0, sof}, 8'd0);
      check("R2", "eof after reset", {7'd0, eof}, 8'd0);
      check("R2", "out_valid after reset", {7'd0, out_valid}, 8'd0);
      check("R2", "frame_err after reset", {7'd0, frame_err}, 8'd0);
      rst_n = 1'b1;
      // R9: stray strobe during the post-reset wait restarts it; R2 ignored byte
      byte_after(B_T35 - 5, 8'hAA);
      byte_after(B_T35 - 1, 8'hAB);
      idle(B_T35 + 3);
      // R3 / R7 / R6: good frame with gaps of exactly T15 and zero
      byte_after(0, 8'h11);
      byte_after(B_T15, 8'h03);
      byte_after(0, 8'h00);
      byte_after(B_T15 - 1, 8'hC5);
      idle(B_T35 + 2);
      // R6: one-byte frame
      byte_after(0, 8'h5A);
      idle(B_T35 + 1);
      // R4 / R7: gap of T15+1 errors the frame; R9 strobe in errored frame
      byte_after(0, 8'h21);
      byte_after(2, 8'h22);
      byte_after(B_T15 + 1, 8'h23);
      byte_after(B_T35 - 1, 8'h24);
      idle(B_T35 + 4);
      // R8: next good frame clears error
      byte_after(0, 8'h31);
      byte_after(1, 8'h32);
      idle(B_T35);
      // R3: strobe exactly at T35 idle opens immediately
      byte_after(0, 8'h41);
      idle(B_T35 + 1);
      // R1 / all: random frames
      for (int f = 0; f < 300; f++) begin
         int nb = $urandom_range(1, 12);
         for (int b = 0; b < nb; b++) begin
            int g;
            int pick = $urandom_range(0, 19);
            if (pick == 0) g = $urandom_range(B_T15 + 1, B_T35 - 1);
            else if (pick < 4) g = B_T15;
            else g = $urandom_range(0, B_T15);
            byte_after(b == 0 ? 0 : g, 8'($urandom));
         end
         idle($urandom_range(B_T35, B_T35 + 6));
      end
      idle(4);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule